// File: doc/BRIEF.md
# PHY Control Port Handshake Master

This block runs single register reads and writes into the 16-bit internal register space of a serial-link PHY. The PHY exposes that space through a narrow control word and a status word. The control word carries a 16-bit field for an address or data value and four strobes: capture-address, capture-data, write and read. The status word returns an acknowledge bit and a 16-bit read-data field. Each strobe is a full four-phase exchange. The strobe is raised and held until acknowledge goes high. It is then dropped, and the block waits for acknowledge to go low before it moves on.

A client issues one request at a time: an operation (write or read), a 16-bit address and 16-bit write data. `busy` stays high for the whole access. `done` pulses when the access succeeds, and `rdata` holds the last value read. A settling gap comes before the address is driven, and each acknowledge wait polls with a gap between polls. If a wait runs out of polls, the access is abandoned with `timeout_err`. A write of a nonzero value to the PHY's clock/reset register (address 0x7F3F) cannot be acknowledged, because it resets the PHY. For that write the block raises the write strobe together with the data and finishes without waiting.

The controller has these states. ST_IDLE waits for a request. ST_SETTLE counts the settling gap. ST_LOAD puts the phase's value on the low field. ST_STB_HI holds the strobe and polls for acknowledge high. ST_STB_LO holds the strobe low and polls for acknowledge low. ST_FINISH signals completion. The transitions are as follows.
- IDLE→SETTLE on an accepted request.
- SETTLE→LOAD when the gap expires.
- LOAD→STB_HI always.
- STB_HI→STB_LO when acknowledge is seen high.
- STB_LO→LOAD when acknowledge is seen low and another phase follows.
- STB_LO→FINISH when acknowledge is seen low after the last phase, or after the capture-data phase of a clock/reset write.
- STB_HI→IDLE and STB_LO→IDLE when the last poll fails (timeout).
- FINISH→IDLE always.

The phases run in a fixed order. A write runs address, data, write. A read runs address, read.

Top module: `phy_cr_master`

## Requirements
- R1: While reset is held and in the cycle after it is released, `cr_word`, `busy`, `done`, `timeout_err` and `rdata` are all zero.
- R2: `cr_word` carries the address/data field in bits 15:0, capture-address at bit 16, capture-data at bit 17, write at bit 18 and read at bit 19. Bits 31:20 are always zero, and at most one strobe is high at any time.
- R3: In `sr_word`, bit 18 is the acknowledge and bits 15:0 are the read data. All other status bits are ignored.
- R4: Every strobe is a four-phase exchange. The strobe stays high until acknowledge is seen high. It then falls, and the next step waits until acknowledge is seen low. A strobe never falls without a prior acknowledge, except on a timeout.
- R5: After a request is accepted, more than SETTLE_CYCLES cycles pass before capture-address rises. The address is already on bits 15:0 at least one cycle before that rise.
- R6: A write performs capture-address, then capture-data with the write data on bits 15:0, then write, in that order.
- R7: A read performs capture-address, then read. `rdata` takes the status data field from the poll that sees acknowledge high during the read strobe, and changes at no other time.
- R8: A write to address 0x7F3F with nonzero data raises the write strobe with the data once the capture-data exchange has ended. `done` follows in the same cycle, with no acknowledge awaited. The write strobe then stays high until the next request is accepted. With zero data, the same write runs the normal write exchange.
- R9: Each acknowledge wait polls at most RETRY_LIMIT times, with polls POLL_GAP+1 cycles apart and the first poll in the cycle the wait begins. If the strobe is never acknowledged, `timeout_err` rises (RETRY_LIMIT-1)*(POLL_GAP+1)+1 cycles after the strobe rises.
- R10: On a timeout, all strobes return to zero, `busy` falls and `done` does not pulse. `timeout_err` stays high until the next request is accepted, and that request then completes normally.
- R11: A request is accepted only in ST_IDLE. `req_valid` while busy is ignored and causes no PHY access.
- R12: `busy` is high from the cycle after acceptance until the access ends. `done` is a one-cycle pulse that only a successful access produces.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe, taken only when idle |
| req_write | input | 1 | 1 for write, 0 for read |
| req_addr | input | 16 | PHY register address |
| req_wdata | input | 16 | Data for a write |
| busy | output | 1 | Access in progress |
| done | output | 1 | One-cycle success pulse |
| rdata | output | 16 | Data returned by the last read |
| timeout_err | output | 1 | Last access abandoned on a failed wait |
| cr_word | output | 32 | Control word to the PHY |
| sr_word | input | 32 | Status word from the PHY |

## Verification
The hardest situations to reach from the ports are the two timeouts. One is a strobe that is never acknowledged. The other is an acknowledge that never drops after the strobe falls. Each ends with the strobes cleared and the engine back in idle. The bench's PHY model has stall modes that freeze the acknowledge low or high. The exact cycle count from strobe rise to `timeout_err` pins down the poll spacing and the retry count. The clock/reset shortcut is driven directly. The bench shows that `done` lands in the same cycle as the write strobe, while the PHY model's acknowledge delay is still pending.

// File: rtl/phy_cr_pkg.sv
package phy_cr_pkg;

    localparam int FIELD_W    = 16;
    localparam int CR_W       = 32;
    localparam int SR_W       = 32;
    localparam int STB_N      = 4;
    localparam int CR_STB_LSB = 16;
    localparam int SR_ACK_BIT = 18;

    localparam logic [FIELD_W-1:0] CLK_RST_REG = 16'h7F3F;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETTLE,
        ST_LOAD,
        ST_STB_HI,
        ST_STB_LO,
        ST_FINISH
    } cr_state_e;

    // Encoding equals the strobe offset above CR_STB_LSB.
    typedef enum logic [1:0] {
        PH_ADDR  = 2'd0,
        PH_DATA  = 2'd1,
        PH_WRITE = 2'd2,
        PH_READ  = 2'd3
    } cr_phase_e;

endpackage

// File: rtl/phy_cr_countdown.sv
module phy_cr_countdown #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             zero
);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign zero = (cnt_q == '0);

endmodule

// File: rtl/phy_cr_retry.sv
module phy_cr_retry #(
    parameter int RETRY_LIMIT = 5000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic inc,
    output logic last
);

    localparam int RW = (RETRY_LIMIT > 1) ? $clog2(RETRY_LIMIT) : 1;
    localparam logic [RW-1:0] LAST_VAL = RW'(RETRY_LIMIT - 1);

    logic [RW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr) begin
            cnt_q <= '0;
        end else if (inc) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign last = (cnt_q == LAST_VAL);

endmodule

// File: rtl/phy_cr_pack.sv
module phy_cr_pack
    import phy_cr_pkg::*;
(
    input  logic [FIELD_W-1:0] low,
    input  logic [STB_N-1:0]   stb,
    input  logic [SR_W-1:0]    sr_word,
    output logic [CR_W-1:0]    cr_word,
    output logic               ack,
    output logic [FIELD_W-1:0] rd_field
);

    localparam int TOP_LSB = CR_STB_LSB + STB_N;

    assign cr_word[FIELD_W-1:0] = low;

    for (genvar k = 0; k < STB_N; k++) begin : g_stb
        assign cr_word[CR_STB_LSB + k] = stb[k];
    end

    assign cr_word[CR_W-1:TOP_LSB] = '0;

    assign ack      = sr_word[SR_ACK_BIT];
    assign rd_field = sr_word[FIELD_W-1:0];

    logic unused_sr;
    assign unused_sr = ^{sr_word[SR_W-1:SR_ACK_BIT+1], sr_word[SR_ACK_BIT-1:FIELD_W]};

endmodule

// File: rtl/phy_cr_master.sv
module phy_cr_master
    import phy_cr_pkg::*;
#(
    parameter int SETTLE_CYCLES = 20000,
    parameter int POLL_GAP      = 20000,
    parameter int RETRY_LIMIT   = 5000
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    input  logic                req_write,
    input  logic [FIELD_W-1:0]  req_addr,
    input  logic [FIELD_W-1:0]  req_wdata,
    output logic                busy,
    output logic                done,
    output logic [FIELD_W-1:0]  rdata,
    output logic                timeout_err,
    output logic [CR_W-1:0]     cr_word,
    input  logic [SR_W-1:0]     sr_word
);

    localparam int TMR_MAX = (SETTLE_CYCLES > POLL_GAP) ? SETTLE_CYCLES : POLL_GAP;
    localparam int TMR_W   = $clog2(TMR_MAX + 1);

    cr_state_e state_q, state_d;
    cr_phase_e phase_q, phase_d;

    logic               op_wr_q;
    logic [FIELD_W-1:0] addr_q;
    logic [FIELD_W-1:0] wdata_q;
    logic [FIELD_W-1:0] low_q;
    logic [STB_N-1:0]   stb_q;
    logic               hold_wr_q, hold_wr_d;
    logic [FIELD_W-1:0] rdata_q;
    logic               tout_q;

    logic               tmr_load, tmr_zero;
    logic [TMR_W-1:0]   tmr_val;
    logic               rty_clr, rty_inc, rty_last;
    logic               ev_accept, ev_sample, ev_tout, ev_fast;
    logic               ack;
    logic [FIELD_W-1:0] rd_field;
    logic               fast_path;

    phy_cr_countdown #(.CNT_W(TMR_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .zero     (tmr_zero)
    );

    phy_cr_retry #(.RETRY_LIMIT(RETRY_LIMIT)) u_retry (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (rty_clr),
        .inc   (rty_inc),
        .last  (rty_last)
    );

    phy_cr_pack u_pack (
        .low      (low_q),
        .stb      (stb_q),
        .sr_word  (sr_word),
        .cr_word  (cr_word),
        .ack      (ack),
        .rd_field (rd_field)
    );

    assign fast_path = op_wr_q && (addr_q == CLK_RST_REG) && (wdata_q != '0);

    // Next state and control events
    always_comb begin
        state_d   = state_q;
        phase_d   = phase_q;
        tmr_load  = 1'b0;
        tmr_val   = '0;
        rty_clr   = 1'b0;
        rty_inc   = 1'b0;
        ev_accept = 1'b0;
        ev_sample = 1'b0;
        ev_tout   = 1'b0;
        ev_fast   = 1'b0;

        unique case (state_q)
            ST_IDLE: begin
                if (req_valid) begin
                    ev_accept = 1'b1;
                    state_d   = ST_SETTLE;
                    phase_d   = PH_ADDR;
                    tmr_load  = 1'b1;
                    tmr_val   = TMR_W'(SETTLE_CYCLES);
                end
            end
            ST_SETTLE: begin
                if (tmr_zero) begin
                    state_d = ST_LOAD;
                end
            end
            ST_LOAD: begin
                state_d  = ST_STB_HI;
                tmr_load = 1'b1;
                tmr_val  = '0;
                rty_clr  = 1'b1;
            end
            ST_STB_HI: begin
                if (tmr_zero) begin
                    if (ack) begin
                        state_d = ST_STB_LO;
                        rty_clr = 1'b1;
                        if (phase_q == PH_READ) begin
                            ev_sample = 1'b1;
                        end
                    end else if (rty_last) begin
                        ev_tout = 1'b1;
                        state_d = ST_IDLE;
                    end else begin
                        rty_inc  = 1'b1;
                        tmr_load = 1'b1;
                        tmr_val  = TMR_W'(POLL_GAP);
                    end
                end
            end
            ST_STB_LO: begin
                if (tmr_zero) begin
                    if (!ack) begin
                        rty_clr = 1'b1;
                        unique case (phase_q)
                            PH_ADDR: begin
                                phase_d = op_wr_q ? PH_DATA : PH_READ;
                                state_d = ST_LOAD;
                            end
                            PH_DATA: begin
                                if (fast_path) begin
                                    ev_fast = 1'b1;
                                    state_d = ST_FINISH;
                                end else begin
                                    phase_d = PH_WRITE;
                                    state_d = ST_LOAD;
                                end
                            end
                            PH_WRITE, PH_READ: begin
                                state_d = ST_FINISH;
                            end
                            default: state_d = ST_IDLE;
                        endcase
                    end else if (rty_last) begin
                        ev_tout = 1'b1;
                        state_d = ST_IDLE;
                    end else begin
                        rty_inc  = 1'b1;
                        tmr_load = 1'b1;
                        tmr_val  = TMR_W'(POLL_GAP);
                    end
                end
            end
            ST_FINISH: begin
                state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase

        if (ev_fast) begin
            hold_wr_d = 1'b1;
        end else if (ev_accept || ev_tout) begin
            hold_wr_d = 1'b0;
        end else begin
            hold_wr_d = hold_wr_q;
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            phase_q <= PH_ADDR;
        end else begin
            state_q <= state_d;
            phase_q <= phase_d;
        end
    end

    // Registered outputs and request capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_wr_q   <= 1'b0;
            addr_q    <= '0;
            wdata_q   <= '0;
            low_q     <= '0;
            stb_q     <= '0;
            hold_wr_q <= 1'b0;
            rdata_q   <= '0;
            tout_q    <= 1'b0;
        end else begin
            if (ev_accept) begin
                op_wr_q <= req_write;
                addr_q  <= req_addr;
                wdata_q <= req_wdata;
                tout_q  <= 1'b0;
            end
            if ((state_d == ST_LOAD) && (state_q != ST_LOAD)) begin
                if (phase_d == PH_ADDR) begin
                    low_q <= addr_q;
                end else if (phase_d == PH_DATA) begin
                    low_q <= wdata_q;
                end
            end
            stb_q <= ((state_d == ST_STB_HI) ? (STB_N'(1) << phase_d) : '0)
                   | {hold_wr_d, 2'b00};
            hold_wr_q <= hold_wr_d;
            if (ev_sample) begin
                rdata_q <= rd_field;
            end
            if (ev_tout) begin
                tout_q <= 1'b1;
            end
        end
    end

    always_comb begin
        busy        = (state_q != ST_IDLE);
        done        = (state_q == ST_FINISH);
        rdata       = rdata_q;
        timeout_err = tout_q;
    end

endmodule

// File: rtl/phy_cr_master_chk.sv
module phy_cr_master_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic        busy,
    input logic        done,
    input logic [15:0] rdata,
    input logic        timeout_err,
    input logic [31:0] cr_word,
    input logic [31:0] sr_word
);

    logic unused_chk;
    assign unused_chk = ^{sr_word[31:19], sr_word[17:0]};

    // R2
    strobe_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(cr_word[19:16]));

    // R2
    upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cr_word[31:20] == 12'h000);

    // R5
    addr_setup_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cr_word[16]) |-> $stable(cr_word[15:0]));

    // R4
    caddr_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(cr_word[16]) && !timeout_err) |-> $past(sr_word[18]));

    // R4
    read_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(cr_word[19]) && !timeout_err) |-> $past(sr_word[18]));

    // R7
    rdata_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rdata) |-> $past(sr_word[18] && cr_word[19]));

    // R10
    tout_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(timeout_err) |-> (cr_word[19:16] == 4'h0 && !busy && !done));

    // R12
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R12
    done_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !timeout_err);

    // R11
    accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && req_valid) |=> (busy && !timeout_err));

endmodule

bind phy_cr_master phy_cr_master_chk u_chk (.*);

// File: tb/test_phy_cr_master.sv
`timescale 1ns/1ps
module test_phy_cr_master;

    localparam int SETTLE = 6;
    localparam int GAP    = 2;
    localparam int LIMIT  = 6;
    localparam int TOUT_CYC = (LIMIT - 1) * (GAP + 1) + 1;

    localparam int M_NORMAL  = 0;
    localparam int M_STALL_H = 1;
    localparam int M_STALL_L = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [15:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic        busy, done, timeout_err;
    logic [15:0] rdata;
    logic [31:0] cr_word;
    logic [31:0] sr_word = '0;

    always #2.5 clk = ~clk;

    phy_cr_master #(
        .SETTLE_CYCLES (SETTLE),
        .POLL_GAP      (GAP),
        .RETRY_LIMIT   (LIMIT)
    ) i_phy_cr_master (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid   (req_valid),
        .req_write   (req_write),
        .req_addr    (req_addr),
        .req_wdata   (req_wdata),
        .busy        (busy),
        .done        (done),
        .rdata       (rdata),
        .timeout_err (timeout_err),
        .cr_word     (cr_word),
        .sr_word     (sr_word)
    );

    int tests = 0;
    int fails = 0;
    bit finished = 1'b0;

    // PHY model state
    int          cyc = 0;
    int          mode = M_NORMAL;
    int          dly = 0;
    int          ack_cnt = 0;
    logic        ack = 1'b0;
    logic [15:0] rd_q = '0;
    logic [15:0] m_addr = '0;
    logic [15:0] m_data = '0;
    logic [3:0]  prev_stb = '0;
    logic [15:0] phy_mem [64];
    logic [15:0] shadow  [64];
    logic [15:0] seq = '0;
    int          cap_rise_cyc = 0;
    logic [15:0] cap_low = '0;
    int          any_rise_cyc = 0;
    int          wr_rise_cyc = 0;

    // Op tracking
    int accept_cyc = 0;
    int end_cyc = 0;
    bit saw_done = 1'b0;
    bit saw_tout = 1'b0;

    function automatic logic [15:0] init_val(input int i);
        return 16'hC3A0 ^ (16'(i) * 16'h0111);
    endfunction

    function automatic logic [15:0] exp_seq(input bit wr);
        return wr ? 16'h0123 : 16'h0014;
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
        #1;
    endtask

    // PHY responder
    initial begin
        for (int i = 0; i < 64; i++) begin
            phy_mem[i] = init_val(i);
        end
        forever begin
            logic [3:0] stb;
            logic [3:0] rise;
            logic       target;
            bit         blocked;
            @(negedge clk);
            cyc++;
            stb = cr_word[19:16];
            if (!rst_n) begin
                ack = 1'b0;
                ack_cnt = 0;
                prev_stb = '0;
            end else begin
                rise = stb & ~prev_stb;
                if (rise != 4'h0) begin
                    any_rise_cyc = cyc;
                    for (int k = 0; k < 4; k++) begin
                        if (rise[k]) seq = {seq[11:0], 4'(k + 1)};
                    end
                    if (rise[0]) begin
                        cap_rise_cyc = cyc;
                        cap_low = cr_word[15:0];
                    end
                    if (rise[2]) wr_rise_cyc = cyc;
                end
                target = |stb;
                blocked = (mode == M_STALL_H && target) || (mode == M_STALL_L && !target);
                if (ack != target && !blocked) begin
                    if (ack_cnt >= dly) begin
                        ack = target;
                        ack_cnt = 0;
                        if (target) begin
                            if (stb[0]) m_addr = cr_word[15:0];
                            if (stb[1]) m_data = cr_word[15:0];
                            if (stb[2]) phy_mem[m_addr[5:0]] = m_data;
                            if (stb[3]) rd_q = phy_mem[m_addr[5:0]];
                        end
                    end else begin
                        ack_cnt++;
                    end
                end else begin
                    ack_cnt = 0;
                end
                prev_stb = stb;
            end
            sr_word = {13'h1FFF & 13'h0, ack, 2'b00, rd_q};
        end
    end

    task automatic wait_end();
        saw_done = 1'b0;
        saw_tout = 1'b0;
        for (int n = 0; n < 600; n++) begin
            if (done) begin
                saw_done = 1'b1;
                end_cyc = cyc;
                break;
            end
            if (timeout_err && !busy) begin
                saw_tout = 1'b1;
                end_cyc = cyc;
                break;
            end
            tick();
        end
        if (!saw_done && !saw_tout) chk(1'b0, "R12 access never ended", 0, 1);
        tick();
    endtask

    task automatic run_op(input bit wr, input logic [15:0] a, input logic [15:0] d);
        seq = '0;
        req_valid = 1'b1;
        req_write = wr;
        req_addr = a;
        req_wdata = d;
        accept_cyc = cyc;
        tick();
        req_valid = 1'b0;
        wait_end();
        if (wr && saw_done) shadow[a[5:0]] = d;
    endtask

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            fails++;
            tests++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        logic [15:0] a, d;
        bit wr;
        void'($urandom(32'd4242));
        for (int i = 0; i < 64; i++) shadow[i] = init_val(i);

        // R1 reset state
        repeat (3) tick();
        chk(cr_word == 32'h0 && !busy && !done, "R1 outputs during reset", cr_word, 0);
        rst_n = 1'b1;
        tick();
        chk(cr_word == 32'h0 && !busy && !done && !timeout_err && rdata == 16'h0,
            "R1 outputs after reset", {busy, done, timeout_err, rdata}, 0);

        // Directed write
        dly = 2;
        run_op(1'b1, 16'h2001, 16'hBEEF);
        chk(saw_done && !timeout_err, "R12 write completes", {saw_done, timeout_err}, 2'b10);
        chk(seq == exp_seq(1'b1), "R6 write strobe order", seq, exp_seq(1'b1));
        chk(cap_low == 16'h2001, "R5 address on field at capture", cap_low, 16'h2001);
        chk(cap_rise_cyc - accept_cyc > SETTLE, "R5 settle gap", cap_rise_cyc - accept_cyc, SETTLE + 1);
        chk(cr_word[31:16] == 16'h0, "R2 R4 strobes low after access", cr_word, 0);
        chk(phy_mem[6'h01] == 16'hBEEF, "R6 PHY register written", phy_mem[6'h01], 16'hBEEF);

        // Directed read
        run_op(1'b0, 16'h2001, 16'h0);
        chk(seq == exp_seq(1'b0), "R7 read strobe order", seq, exp_seq(1'b0));
        chk(rdata == 16'hBEEF, "R7 R3 read data", rdata, 16'hBEEF);
        chk(!busy && !done, "R12 idle after read", {busy, done}, 0);

        // Random traffic
        for (int i = 0; i < 40; i++) begin
            dly = $urandom % 8;
            a = 16'h2000 + 16'($urandom % 8);
            d = 16'($urandom);
            wr = 1'($urandom);
            run_op(wr, a, d);
            chk(saw_done && seq == exp_seq(wr), wr ? "R6 random write" : "R7 random read",
                seq, exp_seq(wr));
            if (!wr) chk(rdata == shadow[a[5:0]], "R7 random read data", rdata, shadow[a[5:0]]);
        end

        // Clock/reset write with nonzero data
        dly = 4;
        run_op(1'b1, 16'h7F3F, 16'h0001);
        chk(saw_done && end_cyc == wr_rise_cyc, "R8 done with write strobe, no wait",
            end_cyc - wr_rise_cyc, 0);
        chk(seq == 16'h0123, "R8 fast write order", seq, 16'h0123);
        chk(cr_word[18] == 1'b1 && cr_word[15:0] == 16'h0001 && !busy,
            "R8 write strobe held with data", cr_word, 32'h0004_0001);
        tick();
        tick();
        chk(cr_word[19:16] == 4'b0100, "R8 strobe still held while idle", cr_word[19:16], 4'b0100);
        run_op(1'b0, 16'h2002, 16'h0);
        chk(cr_word[19:16] == 4'h0 && rdata == shadow[6'h02], "R8 hold cleared by next request",
            {cr_word[19:16], rdata}, {4'h0, shadow[6'h02]});

        // Clock/reset write with zero data: normal exchange
        dly = 3;
        run_op(1'b1, 16'h7F3F, 16'h0000);
        chk(saw_done && end_cyc > wr_rise_cyc && cr_word[19:16] == 4'h0,
            "R8 zero data waits for acknowledge", end_cyc - wr_rise_cyc, 1);

        // Timeout: acknowledge never rises
        mode = M_STALL_H;
        run_op(1'b0, 16'h2005, 16'h0);
        chk(saw_tout && !saw_done, "R10 stall high times out", {saw_tout, saw_done}, 2'b10);
        chk(end_cyc - any_rise_cyc == TOUT_CYC, "R9 timeout cycle count",
            end_cyc - any_rise_cyc, TOUT_CYC);
        chk(cr_word[19:16] == 4'h0 && !busy && timeout_err, "R10 strobes cleared after timeout",
            {cr_word[19:16], busy, timeout_err}, 6'b000001);
        tick();
        chk(timeout_err, "R10 error flag persists", timeout_err, 1);

        // Timeout: acknowledge never falls
        mode = M_STALL_L;
        dly = 1;
        run_op(1'b1, 16'h2006, 16'h5555);
        chk(saw_tout && !saw_done && !busy, "R4 R10 stuck acknowledge times out",
            {saw_tout, saw_done, busy}, 3'b100);
        chk(cr_word[19:16] == 4'h0, "R10 strobes zero after low-wait timeout", cr_word[19:16], 0);

        // Recovery
        mode = M_NORMAL;
        run_op(1'b0, 16'h2001, 16'h0);
        chk(saw_done && !timeout_err && rdata == shadow[6'h01], "R10 recovery after timeout",
            {timeout_err, rdata}, {1'b0, shadow[6'h01]});

        // Request while busy is ignored
        dly = 2;
        seq = '0;
        req_valid = 1'b1; req_write = 1'b1; req_addr = 16'h2003; req_wdata = 16'h1357;
        tick();
        req_valid = 1'b0;
        tick();
        tick();
        req_valid = 1'b1; req_write = 1'b1; req_addr = 16'h2004; req_wdata = 16'hDEAD;
        tick();
        req_valid = 1'b0;
        wait_end();
        if (saw_done) shadow[6'h03] = 16'h1357;
        chk(saw_done && seq == 16'h0123, "R11 first write completes", seq, 16'h0123);
        for (int k = 0; k < 4; k++) begin
            chk(!busy && cr_word[19:16] == 4'h0, "R11 no second access", {busy, cr_word[19:16]}, 0);
            tick();
        end
        run_op(1'b0, 16'h2004, 16'h0);
        chk(rdata == shadow[6'h04], "R11 busy request had no effect", rdata, shadow[6'h04]);
        run_op(1'b0, 16'h2003, 16'h0);
        chk(rdata == 16'h1357, "R7 accepted write visible", rdata, 16'h1357);

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule